// File: doc/BRIEF.md
# Streaming Pattern Recognizer with Overlap Handling

This block scans a stream of 8-bit symbols and raises a single-cycle flag each time a fixed pattern has just arrived in full. The pattern is set by a parameter at elaboration time. Symbols are consumed one per clock, on cycles where the valid strobe is high. The block never compares the whole pattern against a window of input. It keeps one small state: how many leading pattern symbols are currently matched.

When a symbol does not extend the current partial match, the state does not drop straight back to zero. It steps down through a failure table to the longest pattern prefix that is still a suffix of the input seen so far. It then tests the same symbol again at that shorter prefix. All of these steps happen within one cycle. As a result, patterns with repeated symbols are recognized correctly, and occurrences that share symbols are each reported. The failure table is derived from the pattern parameter at elaboration time.

A thin top ties together two pieces: a control unit that turns reset and valid into a small set of strobes, and a datapath that holds the matched-prefix state and the match flag.

Top module: `strmatch_top`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the matched-prefix state returns to empty and `matchPulse` is low in the following cycle, whatever `symValid` and `symIn` carry.
- R2: When an accepted symbol completes the pattern, `matchPulse` is high for exactly the one cycle after the rising edge that accepted it, and low otherwise. The first pattern symbol is the most significant byte of `PATTERN`.
- R3: A mismatch falls back to the longest pattern prefix that is also a suffix of the accepted input and re-tests the symbol there. For the pattern A B C A B D, the stream A B C A B C A B D gives exactly one pulse, on its final symbol.
- R4: Overlapping occurrences are all reported. After a match, the state continues from the longest proper border of the pattern. For the pattern A B A B, the stream A B A B A B pulses after the 4th and the 6th symbols, and back-to-back copies of A B C A B D pulse once per copy.
- R5: A cycle with `symValid` low is ignored. The state is held, the symbol is discarded, and no pulse follows.
- R6: For any stream, a pulse follows an accepted symbol exactly when the last `PAT_LEN` accepted symbols since reset equal the pattern.
- R7: A reset in the middle of the stream discards any partial match. Symbols before the reset never contribute to a later match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | Qualifies `symIn` in this cycle |
| symIn | input | SYM_W | Incoming symbol |
| matchPulse | output | 1 | One-cycle flag: the pattern has just completed |

## Verification
Two functions can fall in the same cycle: the fall-back after a mismatch and the completion of a match. Completion can also coincide with the start of the next overlapping occurrence. This is provoked with streams where the completing symbol follows a failed attempt, and with a second instance whose self-overlapping pattern A B A B is fed runs of A B. Every cycle is judged against a sliding-window model in the bench, which compares the last accepted symbols with the pattern by brute force. Directed streams, idle gaps, mid-stream resets and a long pseudo-random sweep over a four-letter alphabet are all checked this way.

// File: rtl/strmatch_pkg.sv
package strmatch_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;  // return to empty state
    logic step;   // consume symIn this cycle
  } ctrlStrb_t;

endpackage

// File: rtl/strmatch_ctrl.sv
module strmatch_ctrl
  import strmatch_pkg::*;
(
  input  logic      rst,
  input  logic      symValid,
  output ctrlStrb_t strb
);

  // Reset wins over a valid symbol in the same cycle
  always_comb begin
    strb.clear = rst;
    strb.step  = symValid && !rst;
  end

endmodule

// File: rtl/strmatch_dp.sv
module strmatch_dp
  import strmatch_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int PAT_LEN = 6,
  parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = "ABCABD"
) (
  input  logic             clk,
  input  ctrlStrb_t        strb,
  input  logic [SYM_W-1:0] symIn,
  output logic             matchPulse
);

  localparam int LEN_W = $clog2(PAT_LEN + 1);
  typedef logic [LEN_W-1:0] len_t;
  localparam len_t FULL = len_t'(PAT_LEN);

  // Symbol i of the pattern, i = 0 being the first to arrive
  function automatic logic [SYM_W-1:0] patSym(input int i);
    return PATTERN[(PAT_LEN-1-i)*SYM_W +: SYM_W];
  endfunction

  // Longest proper border of the first k pattern symbols
  function automatic int borderLen(input int k);
    int best;
    best = 0;
    for (int b = 1; b < k; b++) begin
      bit same;
      same = 1'b1;
      for (int j = 0; j < b; j++)
        if (patSym(j) != patSym(k - b + j)) same = 1'b0;
      if (same) best = b;
    end
    return best;
  endfunction

  // Failure table, constant after elaboration
  len_t failTab [PAT_LEN+1];
  assign failTab[0] = '0;
  for (genvar k = 1; k <= PAT_LEN; k++) begin : g_fail
    localparam len_t BORDER = len_t'(borderLen(k));
    assign failTab[k] = BORDER;
  end

  len_t stateQ;
  len_t nextState;
  logic hit;

  // Walk failure links until the symbol extends a prefix or the state is empty
  always_comb begin
    len_t cur;
    logic done;
    cur  = stateQ;
    done = 1'b0;
    for (int it = 0; it <= PAT_LEN; it++) begin
      if (!done) begin
        if (cur < FULL && symIn == patSym(int'(cur))) begin
          cur  = cur + 1'b1;
          done = 1'b1;
        end else if (cur == '0) begin
          done = 1'b1;
        end else begin
          cur = failTab[cur];
        end
      end
    end
    hit       = (cur == FULL);
    nextState = hit ? failTab[PAT_LEN] : cur;
  end

  always_ff @(posedge clk) begin
    if (strb.clear) begin
      stateQ     <= '0;
      matchPulse <= 1'b0;
    end else begin
      matchPulse <= strb.step && hit;
      if (strb.step) stateQ <= nextState;
    end
  end

  // R6
  state_range_chk: assert property (@(posedge clk) disable iff (strb.clear)
    stateQ < FULL);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.step |=> ($stable(stateQ) && !matchPulse));

  // R2
  pulse_cause_chk: assert property (@(posedge clk) disable iff (strb.clear)
    matchPulse |-> $past(strb.step));

  // R3
  grow_by_one_chk: assert property (@(posedge clk) disable iff (strb.clear)
    strb.step |=> ({1'b0, stateQ} <= {1'b0, $past(stateQ)} + 1'b1));

endmodule

// File: rtl/strmatch_top.sv
module strmatch_top
  import strmatch_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int PAT_LEN = 6,
  parameter logic [PAT_LEN*SYM_W-1:0] PATTERN = "ABCABD"
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symIn,
  output logic             matchPulse
);

  ctrlStrb_t strb;

  strmatch_ctrl u_ctrl (
    .rst      (rst),
    .symValid (symValid),
    .strb     (strb)
  );

  strmatch_dp #(
    .SYM_W   (SYM_W),
    .PAT_LEN (PAT_LEN),
    .PATTERN (PATTERN)
  ) u_dp (
    .clk        (clk),
    .strb       (strb),
    .symIn      (symIn),
    .matchPulse (matchPulse)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !matchPulse);

endmodule

// File: tb/strmatch_top_test.sv
module strmatch_top_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       symValid = 1'b0;
  logic [7:0] symIn = 8'h00;
  logic       matchA, matchB;

  localparam logic [47:0] PAT_A = "ABCABD";
  localparam logic [31:0] PAT_B = "ABAB";

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  logic [7:0] hist [8];
  int         histCnt = 0;

  strmatch_top #(.SYM_W(8), .PAT_LEN(6), .PATTERN(PAT_A)) uut (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn), .matchPulse(matchA)
  );

  strmatch_top #(.SYM_W(8), .PAT_LEN(4), .PATTERN(PAT_B)) uutOvl (
    .clk(clk), .rst(rst), .symValid(symValid), .symIn(symIn), .matchPulse(matchB)
  );

  // Brute-force window model: last n accepted symbols equal the pattern
  function automatic bit windowHit(input logic [47:0] pat, input int n);
    if (histCnt < n) return 1'b0;
    for (int i = 0; i < n; i++)
      if (hist[i] != pat[i*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input logic act, input logic exp, input string which);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s): matchPulse=%0b expected %0b", tag, which, act, exp);
    end
  endtask

  // One clock: drive at negedge, judge at the following negedge
  task automatic cycle(input logic r, input logic v, input logic [7:0] s);
    bit expA, expB;
    rst = r; symValid = v; symIn = s;
    expA = 1'b0; expB = 1'b0;
    if (r) histCnt = 0;
    else if (v) begin
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = s;
      histCnt++;
      expA = windowHit(PAT_A, 6);
      expB = windowHit({16'h0, PAT_B}, 4);
    end
    @(posedge clk);
    @(negedge clk);
    check(matchA, expA, "ABCABD");
    check(matchB, expB, "ABAB");
  endtask

  task automatic sendStr(input string str);
    for (int i = 0; i < str.len(); i++) cycle(1'b0, 1'b1, str[i]);
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    // R1: reset dominates valid symbols, including a full pattern
    tag = "R1";
    cycle(1'b1, 1'b1, "A");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, PAT_A[(5-i)*8 +: 8]);
    // R2: single clean occurrence
    tag = "R2";
    sendStr("ABCABD");
    sendStr("XX");
    // R3: fall-back on repeated symbols
    tag = "R3";
    cycle(1'b1, 1'b0, 8'h00);
    sendStr("ABCABCABD");
    sendStr("ABABCABD");
    // R4: overlapping and back-to-back occurrences
    tag = "R4";
    cycle(1'b1, 1'b0, 8'h00);
    sendStr("ABABAB");
    sendStr("ABCABDABCABD");
    sendStr("ABABABAB");
    // R5: invalid cycles are ignored
    tag = "R5";
    cycle(1'b1, 1'b0, 8'h00);
    sendStr("ABC");
    cycle(1'b0, 1'b0, "D");
    cycle(1'b0, 1'b0, "A");
    cycle(1'b0, 1'b0, "B");
    sendStr("AB");
    cycle(1'b0, 1'b0, "C");
    sendStr("D");
    // R7: reset mid-stream drops partial match
    tag = "R7";
    sendStr("ABCAB");
    cycle(1'b1, 1'b1, "A");
    sendStr("D");
    sendStr("ABA");
    cycle(1'b1, 1'b0, 8'h00);
    sendStr("B");
    // R6: pseudo-random sweep over a four-letter alphabet
    tag = "R6";
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[11:4] == 8'h00, lfsr[3:2] != 2'b00, 8'h41 + {6'b0, lfsr[1:0]});
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule